// File: doc/BRIEF.md
# Banked Interrupt Controller with Vector

The block collects 96 level-sensitive interrupt sources in three banks of 32. Each bank has a pending word, a mask word and a fast-select word. A rising level on a source latches its pending bit, and software clears the bit by writing 1 to it. Two CPU request lines come out of the block. The normal IRQ line rises when any source is pending and unmasked. The fast FIQ line rises when such a source is also set in its bank's select word.

The controller has no priority levels. A read-only vector register reports four times the global index (bank × 32 + bit) of the active source. The active source is the lowest-numbered one that is pending and unmasked: the lowest bank wins, then the lowest bit within that bank. A separate found flag, not a zero vector, marks whether any source qualifies. This lets source 0 report vector 0 while IRQ is high. A base-address register holds a word-aligned value for software.

A simple register bus provides a 6-bit byte address, a write strobe, 32-bit write data and combinational read data. All state sits in registers, so IRQ, FIQ and the vector settle during the cycle after any change.

Top module: `banked_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every pending, mask, select and base register clears to 0. After reset, `irq` and `fiq` are 0 and the vector reads 0.
- R2: A source whose level was 0 at the previous clock edge and is 1 at this edge sets its pending bit. A source that stays high does not set the bit again. Pending words are read at byte address 0x10 + 4·bank.
- R3: Writing to a pending word clears each bit written as 1 and leaves each bit written as 0. If a new rising edge arrives in the same cycle, the set takes effect.
- R4: `irq` is 1 exactly when some source is pending and its mask bit, at byte address 0x20 + 4·bank, is 0.
- R5: `fiq` is 1 exactly when some source is pending, unmasked and set in its select word at byte address 0x30 + 4·bank. This source need not be the one that wins the vector.
- R6: The vector at byte address 0x00 reads (bank·32 + bit)·4 for the lowest-indexed pending unmasked source. Masked lower sources are skipped.
- R7: The vector reads 0 when no source is pending and unmasked. The vector also reads 0 when source 0 is the winner, and `irq` is then 1.
- R8: Bus writes to byte address 0x00 leave the vector unchanged.
- R9: A write to the base register at byte address 0x04 stores the data with bits [1:0] forced to 0, and a read returns it.
- R10: Within each register group, address bits [3:2] pick the bank. Slot 3 of the pending, mask and select groups reads 0, and writes to it have no effect on banks 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src | input | 96 | Interrupt source levels, bit n is source n |
| addr | input | 6 | Register byte address |
| wr_en | input | 1 | Write strobe, data taken at the clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The assertions assume that `src` and the bus inputs change only between clock edges and hold steady around each edge. They also assume that reset is applied before any property is relied on, because the edge check compares each source with its level at the previous edge. The bench drives every input on the falling clock edge, opens with a reset, and raises sources only after the masks and selects are programmed. The source-edge property therefore always sees a clean rise for the pending bit it expects.

// File: rtl/banked_irq_pkg.sv
package banked_irq_pkg;

    localparam int NUM_BANKS = 3;
    localparam int BANK_W    = 32;
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 32;
    localparam int SRC_W     = NUM_BANKS * BANK_W;
    localparam int POS_W     = $clog2(BANK_W);
    localparam int IDX_W     = $clog2(SRC_W);
    localparam int VEC_W     = IDX_W + 2;

    // Register group, taken from address bits [5:4]
    typedef enum logic [1:0] {
        GRP_CTRL = 2'd0,
        GRP_PEND = 2'd1,
        GRP_MASK = 2'd2,
        GRP_SEL  = 2'd3
    } grp_t;

    localparam logic [1:0] CTRL_VEC  = 2'd0;
    localparam logic [1:0] CTRL_BASE = 2'd1;

    typedef struct packed {
        grp_t       grp;
        logic [1:0] slot;
    } dec_t;

    typedef struct packed {
        logic             found;
        logic [POS_W-1:0] pos;
    } hit_t;

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.grp  = grp_t'(a[5:4]);
        d.slot = a[3:2];
        return d;
    endfunction

    // Lowest set bit of a word, with an explicit found flag
    function automatic hit_t lowest_set(input logic [BANK_W-1:0] w);
        hit_t h;
        h.found = 1'b0;
        h.pos   = '0;
        for (int i = BANK_W - 1; i >= 0; i--) begin
            if (w[i]) begin
                h.found = 1'b1;
                h.pos   = POS_W'(i);
            end
        end
        return h;
    endfunction

endpackage

// File: rtl/irq_bank.sv
module irq_bank
    import banked_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] src,
    input  logic              wr_pend,
    input  logic              wr_mask,
    input  logic              wr_sel,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] pend,
    output logic [BANK_W-1:0] mask,
    output logic [BANK_W-1:0] sel
);

    logic [BANK_W-1:0] src_prev;
    logic [BANK_W-1:0] rise;
    logic [BANK_W-1:0] clr;

    assign rise = src & ~src_prev;
    assign clr  = wr_pend ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_prev <= '0;
            pend     <= '0;
            mask     <= '0;
            sel      <= '0;
        end else begin
            src_prev <= src;
            pend     <= (pend & ~clr) | rise;   // a new edge wins over a clear
            if (wr_mask) mask <= wdata;
            if (wr_sel)  sel  <= wdata;
        end
    end

endmodule

// File: rtl/irq_vec_find.sv
module irq_vec_find
    import banked_irq_pkg::*;
(
    input  logic [SRC_W-1:0] pend_flat,
    input  logic [SRC_W-1:0] mask_flat,
    input  logic [SRC_W-1:0] sel_flat,
    output logic             any_irq,
    output logic             any_fiq,
    output logic [VEC_W-1:0] vec
);

    hit_t                 hit  [NUM_BANKS];
    logic [NUM_BANKS-1:0] fast;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] live;
        assign live    = pend_flat[b*BANK_W +: BANK_W] & ~mask_flat[b*BANK_W +: BANK_W];
        assign hit[b]  = lowest_set(live);
        assign fast[b] = |(live & sel_flat[b*BANK_W +: BANK_W]);
    end

    logic             found;
    logic [IDX_W-1:0] idx;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (!found && hit[b].found) begin
                found = 1'b1;
                idx   = IDX_W'(b * BANK_W) + IDX_W'(hit[b].pos);
            end
        end
    end

    assign any_irq = found;
    assign any_fiq = |fast;
    assign vec     = {idx, 2'b00};

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import banked_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  src,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              fiq
);

    dec_t dec;
    assign dec = decode_addr(addr);

    logic [BANK_W-1:0] pend_w [NUM_BANKS];
    logic [BANK_W-1:0] mask_w [NUM_BANKS];
    logic [BANK_W-1:0] sel_w  [NUM_BANKS];
    logic [SRC_W-1:0]  pend_flat;
    logic [SRC_W-1:0]  mask_flat;
    logic [SRC_W-1:0]  sel_flat;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit_slot;
        assign hit_slot = wr_en && (dec.slot == 2'(b));

        irq_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .src     (src[b*BANK_W +: BANK_W]),
            .wr_pend (hit_slot && dec.grp == GRP_PEND),
            .wr_mask (hit_slot && dec.grp == GRP_MASK),
            .wr_sel  (hit_slot && dec.grp == GRP_SEL),
            .wdata   (wdata),
            .pend    (pend_w[b]),
            .mask    (mask_w[b]),
            .sel     (sel_w[b])
        );

        assign pend_flat[b*BANK_W +: BANK_W] = pend_w[b];
        assign mask_flat[b*BANK_W +: BANK_W] = mask_w[b];
        assign sel_flat[b*BANK_W +: BANK_W]  = sel_w[b];
    end

    logic [VEC_W-1:0] vec_word;

    irq_vec_find u_find (
        .pend_flat (pend_flat),
        .mask_flat (mask_flat),
        .sel_flat  (sel_flat),
        .any_irq   (irq),
        .any_fiq   (fiq),
        .vec       (vec_word)
    );

    logic [DATA_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (wr_en && dec.grp == GRP_CTRL && dec.slot == CTRL_BASE) begin
            base_q <= {wdata[DATA_W-1:2], 2'b00};
        end
    end

    always_comb begin
        rdata = '0;
        unique case (dec.grp)
            GRP_CTRL: begin
                if (dec.slot == CTRL_VEC)       rdata = DATA_W'(vec_word);
                else if (dec.slot == CTRL_BASE) rdata = base_q;
            end
            GRP_PEND: for (int b = 0; b < NUM_BANKS; b++) if (dec.slot == 2'(b)) rdata = pend_w[b];
            GRP_MASK: for (int b = 0; b < NUM_BANKS; b++) if (dec.slot == 2'(b)) rdata = mask_w[b];
            GRP_SEL:  for (int b = 0; b < NUM_BANKS; b++) if (dec.slot == 2'(b)) rdata = sel_w[b];
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/banked_irq_chk.sv
module banked_irq_chk
    import banked_irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [SRC_W-1:0] src,
    input logic             irq,
    input logic             fiq,
    input logic [VEC_W-1:0] vec_word,
    input logic [SRC_W-1:0] pend_flat,
    input logic [SRC_W-1:0] mask_flat,
    input logic [SRC_W-1:0] sel_flat
);

    logic [SRC_W-1:0] src_q;
    logic [IDX_W-1:0] win;

    always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= src;
    end

    assign win = vec_word[VEC_W-1:2];

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (pend_flat == '0 && mask_flat == '0 && sel_flat == '0));

    assert_edge_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_flat & ($past(src) & ~$past(src_q))) == ($past(src) & ~$past(src_q))));

    assert_irq_R4: assert property (@(posedge clk) disable iff (rst)
        irq == (|(pend_flat & ~mask_flat)));

    assert_fiq_sub_R5: assert property (@(posedge clk) disable iff (rst)
        fiq |-> irq);

    assert_fiq_nosel_R5: assert property (@(posedge clk) disable iff (rst)
        (sel_flat == '0) |-> !fiq);

    assert_vec_range_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> (vec_word[1:0] == 2'b00 && int'(win) < SRC_W));

    assert_vec_live_R6: assert property (@(posedge clk) disable iff (rst)
        (irq && int'(win) < SRC_W) |-> (pend_flat[win] && !mask_flat[win]));

    assert_vec_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (vec_word == '0));

endmodule

bind banked_irq_ctrl banked_irq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .src       (src),
    .irq       (irq),
    .fiq       (fiq),
    .vec_word  (vec_word),
    .pend_flat (pend_flat),
    .mask_flat (mask_flat),
    .sel_flat  (sel_flat)
);

// File: tb/tb_banked_irq_ctrl.sv
`timescale 1ns/1ps
module tb_banked_irq_ctrl;
    import banked_irq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [SRC_W-1:0]  src = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              irq;
    logic              fiq;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    banked_irq_ctrl dut (
        .clk(clk), .rst(rst), .src(src), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq), .fiq(fiq)
    );

    typedef struct packed {
        logic [95:0] s;
        logic [95:0] m;
        logic [95:0] f;
        logic        e_irq;
        logic        e_fiq;
        logic [31:0] e_vec;
    } row_t;

    localparam row_t TBL [6] = '{
        '{96'd1, 96'd0, 96'd0, 1'b1, 1'b0, 32'd0},
        '{(96'd1 << 5) | (96'd1 << 40), 96'd0, 96'd1 << 40, 1'b1, 1'b1, 32'd20},
        '{(96'd1 << 3) | (96'd1 << 70), 96'd1 << 3, 96'd1 << 3, 1'b1, 1'b0, 32'd280},
        '{96'd1 << 95, 96'd0, 96'd1 << 95, 1'b1, 1'b1, 32'd380},
        '{(96'd1 << 33) | (96'd1 << 64), 96'hFFFF_FFFF << 32, 96'd0, 1'b1, 1'b0, 32'd256},
        '{96'd1 << 10, ~96'd0, ~96'd0, 1'b0, 1'b0, 32'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; src = '0; wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    logic [31:0] rd;

    initial begin
        // Table-driven vector, IRQ and FIQ checks
        for (int r = 0; r < 6; r++) begin
            do_reset();
            for (int b = 0; b < 3; b++) begin
                bus_wr(6'h20 + 6'(4 * b), TBL[r].m[b*32 +: 32]);
                bus_wr(6'h30 + 6'(4 * b), TBL[r].f[b*32 +: 32]);
            end
            @(negedge clk);
            src = TBL[r].s;
            @(negedge clk);
            chk($sformatf("R4 irq row %0d", r), {31'd0, irq}, {31'd0, TBL[r].e_irq});
            chk($sformatf("R5 fiq row %0d", r), {31'd0, fiq}, {31'd0, TBL[r].e_fiq});
            bus_rd(6'h00, rd);
            chk($sformatf("R6 R7 vector row %0d", r), rd, TBL[r].e_vec);
        end

        // R1 reset state
        do_reset();
        @(negedge clk);
        bus_rd(6'h10, rd); chk("R1 pending bank0", rd, 32'd0);
        bus_rd(6'h20, rd); chk("R1 mask bank0", rd, 32'd0);
        bus_rd(6'h04, rd); chk("R1 base", rd, 32'd0);
        bus_rd(6'h00, rd); chk("R1 vector", rd, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R2 rising edge on source 37 sets bank1 bit 5
        @(negedge clk); src[37] = 1'b1;
        @(negedge clk);
        bus_rd(6'h14, rd); chk("R2 edge sets pending", rd, 32'h20);

        // R3 writing 0 does not clear
        bus_wr(6'h14, 32'h0);
        bus_rd(6'h14, rd); chk("R3 zero write keeps", rd, 32'h20);

        // R8 vector write ignored (source 37 -> 148)
        bus_wr(6'h00, 32'hFFFF_FFF0);
        bus_rd(6'h00, rd); chk("R8 vector write ignored", rd, 32'd148);

        // R3 write-1 clear while level held; R2 held level does not re-set
        bus_wr(6'h14, 32'h20);
        @(negedge clk);
        bus_rd(6'h14, rd); chk("R3 R2 cleared and held", rd, 32'h0);
        chk("R7 irq low after clear", {31'd0, irq}, 32'd0);

        // R3 simultaneous edge and clear: set wins
        src[37] = 1'b0;
        @(negedge clk);
        addr = 6'h14; wdata = 32'h20; wr_en = 1'b1; src[37] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        bus_rd(6'h14, rd); chk("R3 set beats clear", rd, 32'h20);

        // R9 base register alignment
        bus_wr(6'h04, 32'hDEAD_BEEF);
        bus_rd(6'h04, rd); chk("R9 base aligned", rd, 32'hDEAD_BEEC);

        // R10 bank select and empty slot 3
        bus_wr(6'h28, 32'h0000_0001);
        bus_wr(6'h2C, 32'hFFFF_FFFF);
        bus_rd(6'h28, rd); chk("R10 mask bank2", rd, 32'h1);
        bus_rd(6'h24, rd); chk("R10 mask bank1 untouched", rd, 32'h0);
        bus_rd(6'h20, rd); chk("R10 mask bank0 untouched", rd, 32'h0);
        bus_rd(6'h2C, rd); chk("R10 slot3 reads 0", rd, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule